// File: doc/BRIEF.md
# TDMA Frame Timing Sequencer

This block is a time-triggered microsequencer for a radio baseband. Software writes 16-bit timing instructions into a local instruction memory through a simple load port. The sequencer then runs those instructions against a quarter-bit frame tick. By default a frame is 5000 ticks, counted from 0 to 4999, with one tick per clock. Instructions can hold until a given tick, stall for a number of ticks, write a byte into a small internal register file, load the synchro and offset registers, or stop the sequencer.

The frame tick is the free-running raw counter minus the frame offset, reduced modulo the frame length. A new offset is adopted only when the tick wraps. A fixed lead before the end of the frame marks the frame-switch point. At that point, enabled frame interrupts are pulsed toward an MCU and a DSP. The host can arm a DSP interrupt that stays pending until the DSP acknowledges it, and it can also force a DSP interrupt at once.

Each register write is presented on a one-cycle write bus for the radio serial-port engine. The activation, DSP page and gauging registers are also held locally and driven out.

Top module: `tdma_seq`

## Requirements
- R1: `tick_o` is 0 in the first cycle of reset release and then steps by one per clock. After FRAME_TICKS-1 the offset rule of R8 applies; with offset 0 the tick wraps to 0.
- R2: An instruction carries its opcode in bits 15:13, with SLEEP=0, AT=1, OFFSET=2, SYNCHRO=3, MOVE=4 and WAIT=5. Opcodes 6 and 7 take one cycle each and have no other effect.
- R3: AT holds the sequencer while `tick_o` differs from operand bits 12:0. The following instruction issues in the cycle after the match.
- R4: When WAIT with operand n issues, the following instruction issues exactly n+1 cycles later. With n=0 the WAIT takes one cycle.
- R5: MOVE takes its data byte from bits 12:5 and its register address from bits 4:0. `reg_we_o` is high for one cycle, the cycle after issue, carrying that address and data.
- R5 (continued): The register file holds address 0x06 on `act_lo_o`, 0x07 on `act_hi_o` and 0x10 on `dsp_page_o`, and data bit 0 of address 0x11 on `gauge_en_o`. Each value becomes visible one cycle after the write strobe.
- R6: SLEEP clears the enable bit. A later `en_set_i` resumes execution at the instruction after the SLEEP.
- R7: SYNCHRO loads its operand into `synchro_o` and OFFSET loads its operand into `offset_o`. Both read back unchanged, and both are 0 after reset.
- R8: In the cycle after `tick_o` equals FRAME_TICKS-1, the tick becomes (raw - offset) mod FRAME_TICKS. Here raw counts clocks since reset modulo FRAME_TICKS and offset is `offset_o` at that moment. Between wraps the tick only steps by one.
- R9: `mcu_irq_o` is a one-cycle pulse in the cycle after `tick_o` equals FRAME_TICKS-SWITCH_LEAD, given `mcu_irq_en_i` is high at that point.
- R10: `dsp_arm_i` sets `dsp_pending_o` and `dsp_ack_i` clears it. `dsp_irq_o` pulses at the frame-switch point (timed as in R9) when `dsp_irq_en_i` or the pending flag is set. It also pulses in the cycle after `dsp_force_i`.
- R11: `rewind_i` returns both the load pointer and the execution pointer to instruction address 0.
- R12: `idle_o` is high when the enable bit is clear and no WAIT is in progress. `en_clr_i` takes effect at the next instruction boundary: a running WAIT completes, and the instruction after it does not execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one quarter-bit tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | Write load_data_i at the load pointer, then advance the pointer |
| load_data_i | input | 16 | Instruction word to load |
| rewind_i | input | 1 | Reset the load and execution pointers to 0 |
| en_set_i | input | 1 | Set the enable bit |
| en_clr_i | input | 1 | Clear the enable bit |
| mcu_irq_en_i | input | 1 | MCU frame interrupt enable |
| dsp_irq_en_i | input | 1 | DSP frame interrupt enable |
| dsp_arm_i | input | 1 | Arm a DSP frame interrupt |
| dsp_ack_i | input | 1 | DSP clears the armed interrupt |
| dsp_force_i | input | 1 | Force an immediate DSP interrupt |
| tick_o | output | 13 | Frame tick after the offset is applied |
| synchro_o | output | 13 | Synchro delta register |
| offset_o | output | 13 | Frame offset register |
| idle_o | output | 1 | Sequencer idle |
| dsp_pending_o | output | 1 | Armed DSP interrupt still pending |
| mcu_irq_o | output | 1 | MCU frame interrupt pulse |
| dsp_irq_o | output | 1 | DSP frame interrupt pulse |
| reg_we_o | output | 1 | Internal register write strobe |
| reg_addr_o | output | 5 | Internal register address |
| reg_data_o | output | 8 | Internal register data |
| act_lo_o | output | 8 | Lower activation lines |
| act_hi_o | output | 8 | Upper activation lines |
| dsp_page_o | output | 8 | DSP interrupt page |
| gauge_en_o | output | 1 | Gauging enable |

## Verification
The bench builds the block with FRAME_TICKS=100, SWITCH_LEAD=10 and RAM_DEPTH=16. A frame then lasts 100 cycles, so frame wraps, the offset jump at the frame boundary and several switch-point interrupts all occur within a few thousand cycles. The instruction formats are unchanged at that size. The smaller memory keeps elaboration light and still holds every test program.

// File: rtl/tdma_seq_pkg.sv
package tdma_seq_pkg;
  localparam int unsigned IW  = 16;
  localparam int unsigned OPW = 13;

  typedef enum logic [2:0] {
    OP_SLEEP = 3'd0,
    OP_AT    = 3'd1,
    OP_OFS   = 3'd2,
    OP_SYN   = 3'd3,
    OP_MOVE  = 3'd4,
    OP_WAIT  = 3'd5
  } op_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } seq_st_e;

  localparam logic [4:0] RA_ACT_LO = 5'h06;
  localparam logic [4:0] RA_ACT_HI = 5'h07;
  localparam logic [4:0] RA_PAGE   = 5'h10;
  localparam logic [4:0] RA_GAUGE  = 5'h11;
endpackage

// File: rtl/tdma_frame_timer.sv
module tdma_frame_timer
  import tdma_seq_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 5000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] offset_i,
  output logic [OPW-1:0] tick_o
);
  localparam logic [OPW-1:0] LAST = OPW'(FRAME_TICKS - 1);
  localparam logic [OPW:0]   NMOD = (OPW+1)'(FRAME_TICKS);

  logic [OPW-1:0] raw_q, raw_nxt, eff_q, eff_nxt;
  logic [OPW:0]   diff;

  always_comb begin
    raw_nxt = (raw_q == LAST) ? '0 : raw_q + OPW'(1);
    diff    = {1'b0, raw_nxt} - {1'b0, offset_i};
    if (eff_q == LAST) begin
      if (diff[OPW]) eff_nxt = OPW'(diff + NMOD);
      else           eff_nxt = diff[OPW-1:0];
    end else begin
      eff_nxt = eff_q + OPW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      eff_q <= '0;
    end else begin
      raw_q <= raw_nxt;
      eff_q <= eff_nxt;
    end
  end

  assign tick_o = eff_q;

  a_r1_tick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_q <= LAST);
  a_r8_step_mid_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_q != LAST) |=> (eff_q == $past(eff_q) + OPW'(1)));
endmodule

// File: rtl/tdma_frame_irq.sv
module tdma_frame_irq
  import tdma_seq_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 5000,
  parameter int unsigned SWITCH_LEAD = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] tick_i,
  input  logic           mcu_en_i,
  input  logic           dsp_en_i,
  input  logic           arm_i,
  input  logic           ack_i,
  input  logic           force_i,
  output logic           pending_o,
  output logic           mcu_irq_o,
  output logic           dsp_irq_o
);
  localparam logic [OPW-1:0] SW_TICK = OPW'(FRAME_TICKS - SWITCH_LEAD);

  logic at_sw, pend_q, mcu_q, dsp_q;

  assign at_sw = (tick_i == SW_TICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mcu_q  <= 1'b0;
      dsp_q  <= 1'b0;
    end else begin
      if (arm_i)      pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      mcu_q <= at_sw & mcu_en_i;
      dsp_q <= (at_sw & (dsp_en_i | pend_q)) | force_i;
    end
  end

  assign pending_o = pend_q;
  assign mcu_irq_o = mcu_q;
  assign dsp_irq_o = dsp_q;

  a_r9_mcu_at_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcu_q |-> $past(tick_i == SW_TICK));
  a_r9_mcu_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcu_q |=> !mcu_q);
  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !arm_i) |=> !pend_q);
endmodule

// File: rtl/tdma_move_regs.sv
module tdma_move_regs
  import tdma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [4:0] addr_i,
  input  logic [7:0] data_i,
  output logic [7:0] act_lo_o,
  output logic [7:0] act_hi_o,
  output logic [7:0] page_o,
  output logic       gauge_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_lo_o <= '0;
      act_hi_o <= '0;
      page_o   <= '0;
      gauge_o  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        RA_ACT_LO: act_lo_o <= data_i;
        RA_ACT_HI: act_hi_o <= data_i;
        RA_PAGE:   page_o   <= data_i;
        RA_GAUGE:  gauge_o  <= data_i[0];
        default: ;
      endcase
    end
  end

  a_r5_act_lo_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_ACT_LO) |=> (act_lo_o == $past(data_i)));
  a_r5_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == RA_PAGE) |=> $stable(page_o));
endmodule

// File: rtl/tdma_seq_core.sv
module tdma_seq_core
  import tdma_seq_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_we_i,
  input  logic [IW-1:0]  load_data_i,
  input  logic           rewind_i,
  input  logic           en_set_i,
  input  logic           en_clr_i,
  input  logic [OPW-1:0] tick_i,
  output logic [OPW-1:0] synchro_o,
  output logic [OPW-1:0] offset_o,
  output logic           idle_o,
  output logic           mv_we_o,
  output logic [4:0]     mv_addr_o,
  output logic [7:0]     mv_data_o
);
  localparam int unsigned AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

  logic [IW-1:0]  mem_q [RAM_DEPTH];
  logic [AW-1:0]  ld_q, pc_q;
  logic           en_q;
  seq_st_e        st_q;
  logic [OPW-1:0] cnt_q;

  logic [IW-1:0]  instr;
  logic [2:0]     op;
  logic [OPW-1:0] opnd;
  logic           issue, adv;

  always_comb begin
    instr = mem_q[pc_q];
    op    = instr[15:13];
    opnd  = instr[OPW-1:0];
    issue = en_q && (st_q == ST_RUN);
    adv   = issue && ((op != OP_AT) || (tick_i == opnd));
  end

  always_ff @(posedge clk_i) begin
    if (load_we_i && !rewind_i) mem_q[ld_q] <= load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q      <= '0;
      pc_q      <= '0;
      en_q      <= 1'b0;
      st_q      <= ST_RUN;
      cnt_q     <= '0;
      synchro_o <= '0;
      offset_o  <= '0;
      mv_we_o   <= 1'b0;
      mv_addr_o <= '0;
      mv_data_o <= '0;
    end else begin
      mv_we_o <= 1'b0;
      if (rewind_i) begin
        ld_q  <= '0;
        pc_q  <= '0;
        st_q  <= ST_RUN;
        cnt_q <= '0;
      end else begin
        if (load_we_i) ld_q <= ld_q + AW'(1);
        if (st_q == ST_WAIT) begin
          cnt_q <= cnt_q - OPW'(1);
          if (cnt_q == OPW'(1)) st_q <= ST_RUN;
        end else if (adv) begin
          pc_q <= pc_q + AW'(1);
          unique case (op)
            OP_SLEEP: en_q <= 1'b0;
            OP_OFS:   offset_o  <= opnd;
            OP_SYN:   synchro_o <= opnd;
            OP_MOVE: begin
              mv_we_o   <= 1'b1;
              mv_addr_o <= instr[4:0];
              mv_data_o <= instr[12:5];
            end
            OP_WAIT: begin
              if (opnd != '0) begin
                cnt_q <= opnd;
                st_q  <= ST_WAIT;
              end
            end
            default: ;
          endcase
        end
      end
      if (en_clr_i) en_q <= 1'b0;
      if (en_set_i) en_q <= 1'b1;
    end
  end

  assign idle_o = !en_q && (st_q == ST_RUN);

  a_r4_wait_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (cnt_q != '0));
  a_r6_sleep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && op == OP_SLEEP && !rewind_i && !en_set_i) |=> idle_o);
  a_r5_move_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_we_o |-> $past(issue));
endmodule

// File: rtl/tdma_seq.sv
module tdma_seq
  import tdma_seq_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 5000,
  parameter int unsigned SWITCH_LEAD = 10,
  parameter int unsigned RAM_DEPTH   = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_we_i,
  input  logic [15:0] load_data_i,
  input  logic        rewind_i,
  input  logic        en_set_i,
  input  logic        en_clr_i,
  input  logic        mcu_irq_en_i,
  input  logic        dsp_irq_en_i,
  input  logic        dsp_arm_i,
  input  logic        dsp_ack_i,
  input  logic        dsp_force_i,
  output logic [12:0] tick_o,
  output logic [12:0] synchro_o,
  output logic [12:0] offset_o,
  output logic        idle_o,
  output logic        dsp_pending_o,
  output logic        mcu_irq_o,
  output logic        dsp_irq_o,
  output logic        reg_we_o,
  output logic [4:0]  reg_addr_o,
  output logic [7:0]  reg_data_o,
  output logic [7:0]  act_lo_o,
  output logic [7:0]  act_hi_o,
  output logic [7:0]  dsp_page_o,
  output logic        gauge_en_o
);
  logic [OPW-1:0] tick, ofs;
  logic           we;
  logic [4:0]     addr;
  logic [7:0]     data;

  tdma_frame_timer #(.FRAME_TICKS(FRAME_TICKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .offset_i(ofs), .tick_o(tick)
  );

  tdma_seq_core #(.RAM_DEPTH(RAM_DEPTH)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_we_i(load_we_i), .load_data_i(load_data_i),
    .rewind_i(rewind_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .tick_i(tick), .synchro_o(synchro_o), .offset_o(ofs), .idle_o(idle_o),
    .mv_we_o(we), .mv_addr_o(addr), .mv_data_o(data)
  );

  tdma_frame_irq #(.FRAME_TICKS(FRAME_TICKS), .SWITCH_LEAD(SWITCH_LEAD)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .mcu_en_i(mcu_irq_en_i), .dsp_en_i(dsp_irq_en_i),
    .arm_i(dsp_arm_i), .ack_i(dsp_ack_i), .force_i(dsp_force_i),
    .pending_o(dsp_pending_o), .mcu_irq_o(mcu_irq_o), .dsp_irq_o(dsp_irq_o)
  );

  tdma_move_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .data_i(data),
    .act_lo_o(act_lo_o), .act_hi_o(act_hi_o), .page_o(dsp_page_o),
    .gauge_o(gauge_en_o)
  );

  assign tick_o     = tick;
  assign offset_o   = ofs;
  assign reg_we_o   = we;
  assign reg_addr_o = addr;
  assign reg_data_o = data;
endmodule

// File: tb/tdma_seq_tb.sv
module tdma_seq_tb;
  localparam int N    = 100;
  localparam int LEAD = 10;
  localparam int SW   = N - LEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 0, rewind = 0, en_set = 0, en_clr = 0;
  logic [15:0] load_data = '0;
  logic        mcu_en = 0, dsp_en = 0, arm = 0, ack = 0, frc = 0;
  logic [12:0] tick, syn, ofs;
  logic        idle, pend, mcu_irq, dsp_irq, we, gauge;
  logic [4:0]  addr;
  logic [7:0]  data, act_lo, act_hi, page;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tdma_seq #(.FRAME_TICKS(N), .SWITCH_LEAD(LEAD), .RAM_DEPTH(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_we_i(load_we), .load_data_i(load_data),
    .rewind_i(rewind), .en_set_i(en_set), .en_clr_i(en_clr),
    .mcu_irq_en_i(mcu_en), .dsp_irq_en_i(dsp_en), .dsp_arm_i(arm),
    .dsp_ack_i(ack), .dsp_force_i(frc), .tick_o(tick), .synchro_o(syn),
    .offset_o(ofs), .idle_o(idle), .dsp_pending_o(pend), .mcu_irq_o(mcu_irq),
    .dsp_irq_o(dsp_irq), .reg_we_o(we), .reg_addr_o(addr), .reg_data_o(data),
    .act_lo_o(act_lo), .act_hi_o(act_hi), .dsp_page_o(page), .gauge_en_o(gauge)
  );

  function automatic logic [15:0] i_at(int t);   return {3'd1, 13'(t)}; endfunction
  function automatic logic [15:0] i_ofs(int t);  return {3'd2, 13'(t)}; endfunction
  function automatic logic [15:0] i_syn(int t);  return {3'd3, 13'(t)}; endfunction
  function automatic logic [15:0] i_wait(int t); return {3'd5, 13'(t)}; endfunction
  function automatic logic [15:0] i_mv(int a, int d); return {3'd4, 8'(d), 5'(a)}; endfunction
  localparam logic [15:0] I_SLEEP = 16'h0000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at tick %0d", req, act, exp, tick);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick(input int t);
    for (int i = 0; i < 3 * N; i++) begin
      if (tick == 13'(t)) return;
      @(negedge clk);
    end
    chk(0, "wait_tick", tick, t);
  endtask

  task automatic do_rewind();
    rewind = 1; cyc(1); rewind = 0;
  endtask

  task automatic load(input logic [15:0] w);
    load_we = 1; load_data = w; cyc(1); load_we = 0;
  endtask

  task automatic start_at5();
    wait_tick(5);
    en_set = 1; cyc(1); en_set = 0;
  endtask

  task automatic t_reset();
    chk(tick == 1, "R1 tick after reset", tick, 1);
    chk(idle == 1, "R12 idle after reset", idle, 1);
    chk(syn == 0 && ofs == 0, "R7 regs reset", syn + ofs, 0);
    chk(we == 0 && mcu_irq == 0 && dsp_irq == 0, "R9 quiet after reset", we, 0);
    wait_tick(N - 1); cyc(1);
    chk(tick == 0, "R1 wrap", tick, 0);
  endtask

  task automatic t_move();
    do_rewind();
    load(i_at(40)); load(i_mv(6, 8'hA5)); load(I_SLEEP);
    start_at5();
    wait_tick(41);
    chk(we == 0, "R3 no write before match", we, 0);
    chk(idle == 0, "R12 busy while holding", idle, 0);
    cyc(1);
    chk(we == 1, "R3 R5 write strobe", we, 1);
    chk(addr == 5'h06, "R5 address", addr, 6);
    chk(data == 8'hA5, "R5 data", data, 8'hA5);
    cyc(1);
    chk(act_lo == 8'hA5 && we == 0, "R5 act_lo", act_lo, 8'hA5);
    cyc(3);
    chk(idle == 1, "R6 sleep idles", idle, 1);
  endtask

  task automatic t_wait();
    do_rewind();
    load(i_at(20)); load(i_wait(7)); load(i_mv(5'h10, 8'h3C)); load(I_SLEEP);
    start_at5();
    wait_tick(29);
    chk(we == 0, "R4 wait early", we, 0);
    cyc(1);
    chk(we == 1 && addr == 5'h10, "R4 wait n", we, 1);
    cyc(1);
    chk(page == 8'h3C, "R5 dsp page", page, 8'h3C);
  endtask

  task automatic t_wait0_undef();
    do_rewind();
    load(i_at(20)); load(i_wait(0)); load(i_mv(5'h11, 8'h01));
    load(i_at(60)); load(16'hC000); load(i_mv(7, 8'h5A)); load(I_SLEEP);
    start_at5();
    wait_tick(22);
    chk(we == 0, "R4 wait zero early", we, 0);
    cyc(1);
    chk(we == 1 && addr == 5'h11, "R4 wait zero", we, 1);
    cyc(1);
    chk(gauge == 1, "R5 gauge", gauge, 1);
    wait_tick(62);
    chk(we == 0, "R2 undefined early", we, 0);
    cyc(1);
    chk(we == 1 && addr == 5'h07, "R2 undefined one cycle", we, 1);
    cyc(1);
    chk(act_hi == 8'h5A, "R5 act_hi", act_hi, 8'h5A);
  endtask

  task automatic t_resume();
    do_rewind();
    load(i_at(10)); load(i_mv(6, 1)); load(I_SLEEP); load(i_mv(6, 2)); load(I_SLEEP);
    start_at5();
    wait_tick(20);
    chk(act_lo == 1 && idle == 1, "R6 stopped at sleep", act_lo, 1);
    en_set = 1; cyc(1); en_set = 0;
    cyc(5);
    chk(act_lo == 2, "R6 resume after sleep", act_lo, 2);
    chk(idle == 1, "R6 second sleep", idle, 1);
  endtask

  task automatic t_rewind();
    do_rewind();
    load(i_mv(6, 8'h77)); load(I_SLEEP);
    do_rewind();
    load(i_mv(6, 8'h33)); load(I_SLEEP);
    en_set = 1; cyc(1); en_set = 0;
    cyc(5);
    chk(act_lo == 8'h33, "R11 rewind reload", act_lo, 8'h33);
  endtask

  task automatic t_irq();
    mcu_en = 1;
    wait_tick(SW);
    chk(mcu_irq == 0, "R9 not yet", mcu_irq, 0);
    cyc(1);
    chk(mcu_irq == 1, "R9 mcu pulse", mcu_irq, 1);
    chk(dsp_irq == 0, "R10 dsp quiet", dsp_irq, 0);
    cyc(1);
    chk(mcu_irq == 0, "R9 one cycle", mcu_irq, 0);
    mcu_en = 0;
    wait_tick(SW + 1);
    chk(mcu_irq == 0, "R9 disabled", mcu_irq, 0);
    arm = 1; cyc(1); arm = 0;
    chk(pend == 1, "R10 armed", pend, 1);
    wait_tick(SW + 1);
    chk(dsp_irq == 1, "R10 armed pulse", dsp_irq, 1);
    chk(pend == 1, "R10 still pending", pend, 1);
    ack = 1; cyc(1); ack = 0;
    chk(pend == 0, "R10 ack clears", pend, 0);
    wait_tick(SW + 1);
    chk(dsp_irq == 0, "R10 no pulse after ack", dsp_irq, 0);
    wait_tick(50);
    frc = 1; cyc(1); frc = 0;
    chk(dsp_irq == 1, "R10 force", dsp_irq, 1);
    cyc(1);
    chk(dsp_irq == 0, "R10 force one cycle", dsp_irq, 0);
  endtask

  task automatic t_disable();
    do_rewind();
    load(i_at(20)); load(i_wait(30)); load(i_mv(7, 8'h11)); load(I_SLEEP);
    start_at5();
    wait_tick(25);
    en_clr = 1; cyc(1); en_clr = 0;
    wait_tick(45);
    chk(idle == 0, "R12 wait runs on", idle, 0);
    wait_tick(53);
    chk(idle == 1, "R12 idle after wait", idle, 1);
    wait_tick(60);
    chk(act_hi == 8'h5A, "R12 next not executed", act_hi, 8'h5A);
  endtask

  task automatic t_offset();
    do_rewind();
    load(i_syn(123)); load(i_ofs(30)); load(I_SLEEP);
    start_at5();
    cyc(10);
    chk(syn == 123, "R7 synchro", syn, 123);
    chk(ofs == 30, "R7 offset", ofs, 30);
    wait_tick(N - 1); cyc(1);
    chk(tick == N - 30, "R8 offset at boundary", tick, N - 30);
    wait_tick(N - 1); cyc(1);
    chk(tick == 0, "R8 steady wrap", tick, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_move();
    t_wait();
    t_wait0_undef();
    t_resume();
    t_rewind();
    t_irq();
    t_disable();
    t_offset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule